// File: doc/BRIEF.md
# Instruction Page Stack Controller

This block keeps track of which alternate opcode page the front end should use when it decodes 16-bit compressed instructions. Software chooses a page by retiring a page-select instruction. That instruction carries a subpage number and an active length, and the block pushes both onto a small stack of selections. Each temporary selection expires after a set number of ordinary retired instructions. A taken branch drops all temporary selections. Two dedicated instructions are also available: one returns decoding straight to the base instruction set, and the other steps back by one level.

The retire side is a plain control interface and has no back-pressure. Every cycle that has `retire_vld` high stands for one retired instruction, and the block takes it in that same cycle. The flags state whether the instruction was page control. A high `branch_taken` in any cycle requests a flush of the temporary selections. All outputs come from registers. The current page, the stack depth and a flat CSR image of the stack change on the clock edge after the event that causes the change.

Top module: `page_stack_ctrl`

## Requirements
- R1: When a retire has `retire_sel` set, `retire_home` and `retire_pop` clear, and the depth is below DEPTH, the entry {`sel_page`, `sel_len`} is placed on top. After the next edge the depth has grown by one and `cur_page` equals `sel_page`.
- R2: `depth` stays between 0 and DEPTH. `csr_stack` holds entry i (0 = bottom) in bits [i*7 +: 7], with the page in bits [i*7+4 +: 3] and the length in bits [i*7 +: 4]. Slots at or above the depth read as zero.
- R3: A top entry whose length is 4'b1111 is permanent. An ordinary retire leaves it, and the whole stack, unchanged.
- R4: An ordinary retire (`retire_vld` with all three flags clear) decrements a top length L in 1..14. The retire that finds L equal to 1 removes the entry instead. A length of 0 behaves like 1.
- R5: After a cycle with `branch_taken` high, entries are removed from the top until the top is permanent or the stack is empty. This happens after that cycle's retire has been applied.
- R6: A retire with `retire_home` set empties the stack in one cycle.
- R7: A retire with `retire_pop` set (and `retire_home` clear) removes exactly one entry. At depth 0 it has no effect.
- R8: A push at depth DEPTH leaves the stack unchanged and sets `csr_ovf`. `csr_ovf` stays set until reset.
- R9: At depth 0 the `cur_page` output is 0, which selects the base instruction set.
- R10: When several flags are set, home wins over pop, and pop wins over select. Page-control retires never decrement a length.
- R11: During and right after reset, the depth is 0, `cur_page` is 0, `csr_stack` is 0 and `csr_ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_vld | input | 1 | One instruction retires this cycle |
| retire_sel | input | 1 | The retiring instruction is a page select |
| retire_home | input | 1 | The retiring instruction returns to the base instruction set |
| retire_pop | input | 1 | The retiring instruction drops one level |
| sel_page | input | SUB_W | Subpage number of a page select |
| sel_len | input | LEN_W | Active length of a page select (all ones = permanent) |
| branch_taken | input | 1 | A branch was taken this cycle |
| cur_page | output | SUB_W | Page of the top entry, 0 when the stack is empty |
| depth | output | $clog2(DEPTH+1) | Number of live entries |
| csr_stack | output | DEPTH*(SUB_W+LEN_W) | CSR image of the stack, live entries only |
| csr_ovf | output | 1 | Sticky push-overflow flag |

## Verification
The bench builds the block with its default parameters: four levels, 3-bit pages and 4-bit lengths. At that size a full stack and the overflow case can be reached within a handful of pushes, and the permanent length code 4'b1111 is easy to hit in random traffic. The directed sequences cover a branch that lands on mixed stacks of permanent and temporary entries, a push combined with a branch in the same cycle, and retires that raise conflicting flags. A long random phase then mixes every kind of retire with branches while the CSR image is compared in full on every cycle.

// File: rtl/pgstk_pkg.sv
package pgstk_pkg;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_HOME = 3'd1,
    OP_POP  = 3'd2,
    OP_PUSH = 3'd3,
    OP_STEP = 3'd4
  } pg_op_e;

  // Flag priority: home, then pop, then select; plain retire counts down.
  function automatic pg_op_e decode_op(input logic vld, input logic home,
                                       input logic pop, input logic sel);
    if (!vld)      return OP_IDLE;
    else if (home) return OP_HOME;
    else if (pop)  return OP_POP;
    else if (sel)  return OP_PUSH;
    else           return OP_STEP;
  endfunction

endpackage

// File: rtl/pgstk_step.sv
module pgstk_step
  import pgstk_pkg::*;
#(
  parameter int SUB_W = 3,
  parameter int LEN_W = 4,
  parameter int DEPTH = 4
) (
  input  pg_op_e                           op,
  input  logic [DEPTH*(SUB_W+LEN_W)-1:0]   ent_q,
  input  logic [$clog2(DEPTH+1)-1:0]       depth_q,
  input  logic [SUB_W-1:0]                 sel_page,
  input  logic [LEN_W-1:0]                 sel_len,
  output logic [DEPTH*(SUB_W+LEN_W)-1:0]   ent_d,
  output logic [$clog2(DEPTH+1)-1:0]       depth_d,
  output logic                             ovf_set
);
  localparam int EW = SUB_W + LEN_W;
  localparam int DW = $clog2(DEPTH + 1);
  localparam logic [LEN_W-1:0] PERM = {LEN_W{1'b1}};

  int              top_idx;
  logic [LEN_W-1:0] top_len;

  always_comb begin
    top_idx = (depth_q == '0) ? 0 : int'(depth_q) - 1;
    top_len = (depth_q == '0) ? '0 : ent_q[top_idx*EW +: LEN_W];
  end

  always_comb begin
    ent_d   = ent_q;
    depth_d = depth_q;
    ovf_set = 1'b0;
    unique case (op)
      OP_HOME: depth_d = '0;
      OP_POP: begin
        if (depth_q != '0) depth_d = depth_q - DW'(1);
      end
      OP_PUSH: begin
        if (int'(depth_q) < DEPTH) begin
          ent_d[int'(depth_q)*EW +: EW] = {sel_page, sel_len};
          depth_d = depth_q + DW'(1);
        end else begin
          ovf_set = 1'b1;
        end
      end
      OP_STEP: begin
        if (depth_q != '0 && top_len != PERM) begin
          if (top_len <= LEN_W'(1)) depth_d = depth_q - DW'(1);
          else ent_d[top_idx*EW +: LEN_W] = top_len - LEN_W'(1);
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pgstk_flush.sv
module pgstk_flush #(
  parameter int SUB_W = 3,
  parameter int LEN_W = 4,
  parameter int DEPTH = 4
) (
  input  logic [DEPTH*(SUB_W+LEN_W)-1:0] ent,
  input  logic [$clog2(DEPTH+1)-1:0]     depth_in,
  input  logic                           flush,
  output logic [$clog2(DEPTH+1)-1:0]     depth_out
);
  localparam int EW = SUB_W + LEN_W;
  localparam int DW = $clog2(DEPTH + 1);
  localparam logic [LEN_W-1:0] PERM = {LEN_W{1'b1}};

  logic [DW-1:0] keep;

  // Highest permanent live entry decides how much survives a branch.
  always_comb begin
    keep = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(depth_in) && ent[i*EW +: LEN_W] == PERM) keep = DW'(i + 1);
    end
    depth_out = flush ? keep : depth_in;
  end

endmodule

// File: rtl/pgstk_view.sv
module pgstk_view #(
  parameter int SUB_W = 3,
  parameter int LEN_W = 4,
  parameter int DEPTH = 4
) (
  input  logic [DEPTH*(SUB_W+LEN_W)-1:0] ent,
  input  logic [$clog2(DEPTH+1)-1:0]     depth,
  output logic [DEPTH*(SUB_W+LEN_W)-1:0] image,
  output logic [SUB_W-1:0]               page,
  output logic [LEN_W-1:0]               top_len
);
  localparam int EW = SUB_W + LEN_W;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign image[g*EW +: EW] = (g < int'(depth)) ? ent[g*EW +: EW] : '0;
  end

  always_comb begin
    page    = '0;
    top_len = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i == int'(depth) - 1) begin
        page    = ent[i*EW + LEN_W +: SUB_W];
        top_len = ent[i*EW +: LEN_W];
      end
    end
  end

endmodule

// File: rtl/page_stack_ctrl.sv
module page_stack_ctrl
  import pgstk_pkg::*;
#(
  parameter int SUB_W = 3,
  parameter int LEN_W = 4,
  parameter int DEPTH = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           retire_vld,
  input  logic                           retire_sel,
  input  logic                           retire_home,
  input  logic                           retire_pop,
  input  logic [SUB_W-1:0]               sel_page,
  input  logic [LEN_W-1:0]               sel_len,
  input  logic                           branch_taken,
  output logic [SUB_W-1:0]               cur_page,
  output logic [$clog2(DEPTH+1)-1:0]     depth,
  output logic [DEPTH*(SUB_W+LEN_W)-1:0] csr_stack,
  output logic                           csr_ovf
);
  localparam int EW = SUB_W + LEN_W;
  localparam int DW = $clog2(DEPTH + 1);
  localparam logic [LEN_W-1:0] PERM = {LEN_W{1'b1}};

  logic [DEPTH*EW-1:0] ent_q, ent_d;
  logic [DW-1:0]       depth_q, depth_s, depth_d;
  logic                ovf_q, ovf_set;
  logic [LEN_W-1:0]    top_len;
  pg_op_e              op;

  assign op = decode_op(retire_vld, retire_home, retire_pop, retire_sel);

  pgstk_step #(.SUB_W(SUB_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) u_step (
    .op(op), .ent_q(ent_q), .depth_q(depth_q),
    .sel_page(sel_page), .sel_len(sel_len),
    .ent_d(ent_d), .depth_d(depth_s), .ovf_set(ovf_set)
  );

  pgstk_flush #(.SUB_W(SUB_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) u_flush (
    .ent(ent_d), .depth_in(depth_s), .flush(branch_taken), .depth_out(depth_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q   <= '0;
      depth_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      ent_q   <= ent_d;
      depth_q <= depth_d;
      ovf_q   <= ovf_q | ovf_set;
    end
  end

  pgstk_view #(.SUB_W(SUB_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) u_view (
    .ent(ent_q), .depth(depth_q), .image(csr_stack),
    .page(cur_page), .top_len(top_len)
  );

  assign depth   = depth_q;
  assign csr_ovf = ovf_q;

  p_depth_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(depth) <= DEPTH);

  p_perm_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP && depth != '0 && top_len == PERM && !branch_taken)
    |=> ($stable(depth) && $stable(csr_stack)));

  p_branch_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    branch_taken |=> (depth == '0 || top_len == PERM));

  p_home_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld && retire_home) |=> (depth == '0));

  p_pop_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POP && depth != '0 && !branch_taken)
    |=> (int'(depth) == int'($past(depth)) - 1));

  p_full_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH && int'(depth) == DEPTH && !branch_taken)
    |=> ($stable(depth) && csr_ovf));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    csr_ovf |=> csr_ovf);

endmodule

// File: tb/page_stack_ctrl_tb_top.sv
`timescale 1ns/1ps
module page_stack_ctrl_tb_top;
  localparam int SUB_W = 3;
  localparam int LEN_W = 4;
  localparam int DEPTH = 4;
  localparam int DW    = $clog2(DEPTH + 1);
  localparam int EW    = SUB_W + LEN_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic r_vld = 0, r_sel = 0, r_home = 0, r_pop = 0, br = 0;
  logic [SUB_W-1:0] pg = '0;
  logic [LEN_W-1:0] ln = '0;
  logic [SUB_W-1:0] cur_page;
  logic [DW-1:0]    depth;
  logic [DEPTH*EW-1:0] csr_stack;
  logic             csr_ovf;

  int n_vec = 0, n_bad = 0;
  string cur_req = "R11";
  bit done = 0;

  int qp[$];
  int ql[$];
  bit m_ovf = 0;

  always #2 clk = ~clk;

  page_stack_ctrl #(.SUB_W(SUB_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .retire_vld(r_vld), .retire_sel(r_sel),
    .retire_home(r_home), .retire_pop(r_pop), .sel_page(pg), .sel_len(ln),
    .branch_taken(br), .cur_page(cur_page), .depth(depth),
    .csr_stack(csr_stack), .csr_ovf(csr_ovf)
  );

  task automatic model_pop();
    void'(qp.pop_back());
    void'(ql.pop_back());
  endtask

  // Behavioural reference, updated on every rising edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qp.delete(); ql.delete(); m_ovf = 0;
    end else begin
      if (r_vld) begin
        if (r_home) begin
          qp.delete(); ql.delete();
        end else if (r_pop) begin
          if (qp.size() > 0) model_pop();
        end else if (r_sel) begin
          if (qp.size() < DEPTH) begin qp.push_back(int'(pg)); ql.push_back(int'(ln)); end
          else m_ovf = 1;
        end else if (qp.size() > 0 && ql[$] != 15) begin
          if (ql[$] <= 1) model_pop();
          else ql[ql.size()-1] = ql[$] - 1;
        end
      end
      if (br) while (qp.size() > 0 && ql[$] != 15) model_pop();
    end
  end

  task automatic compare();
    logic [DEPTH*EW-1:0] exp_img;
    int exp_pg;
    exp_img = '0;
    for (int i = 0; i < qp.size(); i++)
      exp_img = exp_img | ((DEPTH*EW)'(qp[i] * 16 + ql[i]) << (i * EW));
    exp_pg = (qp.size() == 0) ? 0 : qp[$];
    n_vec++;
    if (int'(depth) != qp.size()) begin
      n_bad++; $display("FAIL %s depth: got %0d expected %0d", cur_req, depth, qp.size());
    end
    if (int'(cur_page) != exp_pg) begin
      n_bad++; $display("FAIL %s R9 cur_page: got %0d expected %0d", cur_req, cur_page, exp_pg);
    end
    if (csr_stack !== exp_img) begin
      n_bad++; $display("FAIL %s R2 csr_stack: got %h expected %h", cur_req, csr_stack, exp_img);
    end
    if (csr_ovf !== m_ovf) begin
      n_bad++; $display("FAIL %s R8 csr_ovf: got %0b expected %0b", cur_req, csr_ovf, m_ovf);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) compare();

  task automatic issue(input bit v, input bit s, input bit h, input bit p,
                       input bit b, input int page, input int len);
    @(negedge clk);
    r_vld = v; r_sel = s; r_home = h; r_pop = p; br = b;
    pg = SUB_W'(page); ln = LEN_W'(len);
  endtask

  task automatic push(input int page, input int len); issue(1,1,0,0,0,page,len); endtask
  task automatic step(); issue(1,0,0,0,0,0,0); endtask
  task automatic idle(); issue(0,0,0,0,0,0,0); endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R11: reset state, checked while reset is held and after release
    repeat (3) @(negedge clk);
    compare();
    @(negedge clk); rst_n = 1'b1;
    idle();
    cur_req = "R1";  push(5, 15); idle();
    cur_req = "R3";  repeat (3) step();
    cur_req = "R1";  push(3, 3);
    cur_req = "R4";  repeat (4) step();
    cur_req = "R4";  push(6, 0); step(); idle();
    cur_req = "R7";  push(2, 9); issue(1,0,0,1,0,0,0);
    issue(1,0,0,1,0,0,0); issue(1,0,0,1,0,0,0); idle();
    cur_req = "R8";  push(1,15); push(2,4); push(3,15); push(4,7); push(7,2); idle(); push(6,6); idle();
    cur_req = "R5";  issue(0,0,0,0,1,0,0); idle();
    issue(0,0,0,0,1,0,0); idle();
    push(5, 3); issue(1,1,0,0,1,4,8); idle();
    push(5, 5); issue(1,0,0,0,1,0,0); idle();
    cur_req = "R6";  issue(1,0,1,0,0,0,0); idle();
    cur_req = "R10"; push(3, 15); push(4, 2);
    issue(1,1,1,1,0,6,6); idle();
    push(4, 2); issue(1,1,0,1,0,6,6); idle();
    issue(1,1,0,0,0,7,1); idle(); issue(1,0,0,1,0,0,0);
    cur_req = "R9";  issue(1,0,0,1,0,0,0); idle(); issue(1,0,1,0,0,0,0); idle();
    cur_req = "random";
    for (int k = 0; k < 4000; k++) begin
      int r, l;
      r = $urandom_range(0, 19);
      l = ($urandom_range(0, 2) == 0) ? 15 : $urandom_range(0, 14);
      issue(r < 16, r < 5, r == 5, r == 6 || r == 7, $urandom_range(0, 9) == 0,
            $urandom_range(0, 7), l);
    end
    idle(); idle();
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule